// File: doc/BRIEF.md
# Mode-Gated Port Function Control Register

This block holds three control bits that choose the alternate functions of the upper pins (6, 5 and 4) of an 8-bit general-purpose port. Pin 6 can carry an instruction-queue status bit or a clock-unit test output. Pin 5 can carry the other queue status bit. Pin 4 can carry the bus E clock. Whether a CPU write reaches a bit depends on two things: the operating mode, and whether the register has already been written since reset. The mode is given as a normal/special flag plus a kind: single-chip, expanded or peripheral.

The CPU side is a plain register write strobe with write data and a combinational read-back. The mode inputs are captured while reset is held and are frozen for the rest of the session. A small state machine records whether the first write has happened. It has two states: `ST_FRESH`, entered at reset, and `ST_WRITTEN`, entered on the first write strobe (transition "first write") and never left until reset. Each control bit checks the mode and this state to decide whether a write is accepted. The pin side is a combinational priority mux. For each pin it produces a source select, an output enable and the data to drive, choosing from the GPIO path, the queue status inputs, the clock-test input and the E-clock input.

Top module: `pin_func_ctl`

## Requirements
- R1: While `rst` is high, `rd_data_o` reads 0x00 and the state machine is in `ST_FRESH`. All three control bits reset to 0.
- R2: The clock-test bit (bit 6) is never written in normal mode. In special mode, every write except the first after reset loads it.
- R3: The pipe-status bit (bit 5) is loaded only by the first write after reset in normal mode. In special mode, every write except the first loads it.
- R4: The no-E-clock bit (bit 4) is loaded only by the first write in normal single-chip mode. Every write loads it in special single-chip mode. No write reaches it in any other mode.
- R5: In every mode, `rd_data_o` returns the clock-test bit at bit 6, the pipe-status bit at bit 5 and the no-E-clock bit at bit 4. All other bits read 0.
- R6: When the pipe-status bit is 1 and the mode kind is expanded (`mode_kind_i` 2'b01 or 2'b11), pins 6 and 5 select source 1 (pipe), with output enable 1. Pin 6 drives `pipe_stat_i[1]` and pin 5 drives `pipe_stat_i[0]`. This takes priority over the clock-test function.
- R7: Outside the expanded kinds, the pipe-status bit has no effect on any pin.
- R8: Pin 6 selects source 2 (clock test) in the following case: the clock-test bit is 1, pipe status is not active, and the mode is neither single-chip (2'b00) nor normal expanded. In that case pin 6 has output enable 1 and drives `clk_test_i`.
- R9: Pin 4 selects source 3 (E clock) when the no-E-clock bit is 0 and either the mode is not single-chip or `estr_i` is 0. Otherwise pin 4 is GPIO.
- R10: When pin 4 is the E clock, its output enable is 0 in peripheral mode (2'b10), and its data out is then 0. In every other mode the output enable is 1 and the pin drives `eclk_i`.
- R11: A pin in GPIO function selects source 0. Its output enable follows its `gpio_oe_i` bit and its data follows its `gpio_out_i` bit.
- R12: Changes to `mode_special_i` or `mode_kind_i` after reset is released affect neither the write rules nor the pin functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; mode is captured while high |
| mode_special_i | input | 1 | 1 = special mode, 0 = normal mode |
| mode_kind_i | input | 2 | 00 single-chip, 01 expanded, 10 peripheral, 11 expanded (wide) |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read-back of the register |
| estr_i | input | 1 | E-clock stretch/restrict control, used in single-chip modes |
| pipe_stat_i | input | 2 | Instruction-queue status bits |
| clk_test_i | input | 1 | Clock-unit test signal |
| eclk_i | input | 1 | E clock |
| gpio_out_i | input | 3 | GPIO data for pins 6,5,4 (index 2 = pin 6) |
| gpio_oe_i | input | 3 | GPIO direction for pins 6,5,4 (index 2 = pin 6) |
| pin_sel_o | output | 6 | Source select: [5:4] pin 6, [3:2] pin 5, [1:0] pin 4 |
| pin_oe_o | output | 3 | Output enable for pins 6,5,4 (index 2 = pin 6) |
| pin_do_o | output | 3 | Data driven on pins 6,5,4 (index 2 = pin 6) |

## Verification
The bench resets into all eight mode combinations. In each, it runs two four-write sequences, chosen so that the first write is either a set or a clear, and checks every bit after every write. A design that shares one "first write" rule across all bits would let the clock-test bit take its first special-mode write, or would let the pipe bit take a late normal-mode write, and would read back a wrong value. Pin functions are swept for both `estr_i` levels and for both polarities of every data input. A mux that put the clock test ahead of pipe status, or that forgot to turn pin 4 into an input in peripheral mode, would show the wrong select or enable. Mode inputs are inverted right after reset, so a design that reads the live mode instead of the captured one fails the same sweeps.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        SRC_GPIO    = 2'd0,
        SRC_PIPE    = 2'd1,
        SRC_CLKTEST = 2'd2,
        SRC_ECLK    = 2'd3
    } pin_src_e;

    typedef enum logic {
        ST_FRESH   = 1'b0,
        ST_WRITTEN = 1'b1
    } acc_state_e;

    typedef enum logic [1:0] {
        MK_SINGLE = 2'b00,
        MK_EXP    = 2'b01,
        MK_PERIPH = 2'b10,
        MK_EXPW   = 2'b11
    } mode_kind_e;

    typedef struct packed {
        logic ct;   // clock-test output enable
        logic ps;   // pipe-status output enable
        logic ne;   // no E clock
    } ctl_bits_t;

endpackage

// File: rtl/pfc_mode_latch.sv
module pfc_mode_latch
    import pfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_special_i,
    input  logic [1:0] mode_kind_i,
    output logic       special_q,
    output mode_kind_e kind_q
);

    // Mode follows the pins only while reset is held, then stays frozen.
    always_ff @(posedge clk) begin
        if (rst) begin
            special_q <= mode_special_i;
            kind_q    <= mode_kind_e'(mode_kind_i);
        end
    end

endmodule

// File: rtl/pfc_access.sv
module pfc_access
    import pfc_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int CT_POS = 6,
    parameter int PS_POS = 5,
    parameter int NE_POS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             special_i,
    input  mode_kind_e       kind_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output ctl_bits_t        bits_o,
    output acc_state_e       state_o
);

    acc_state_e state_q, state_d;
    ctl_bits_t  bits_q, bits_d;
    logic       ct_ok, ps_ok, ne_ok;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FRESH;
        else     state_q <= state_d;
    end

    // Next state: the first write strobe moves to ST_WRITTEN for good.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FRESH:   if (wr_en_i) state_d = ST_WRITTEN;
            ST_WRITTEN: state_d = ST_WRITTEN;
        endcase
    end

    // Per-bit acceptance, decoded from mode and access state
    always_comb begin
        ct_ok = 1'b0;
        ps_ok = 1'b0;
        ne_ok = 1'b0;
        unique case (state_q)
            ST_FRESH: begin
                ps_ok = !special_i;
                ne_ok = (kind_i == MK_SINGLE);
            end
            ST_WRITTEN: begin
                ct_ok = special_i;
                ps_ok = special_i;
                ne_ok = (kind_i == MK_SINGLE) && special_i;
            end
        endcase
    end

    always_comb begin
        bits_d = bits_q;
        if (wr_en_i) begin
            if (ct_ok) bits_d.ct = wr_data_i[CT_POS];
            if (ps_ok) bits_d.ps = wr_data_i[PS_POS];
            if (ne_ok) bits_d.ne = wr_data_i[NE_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_d;
    end

    assign bits_o  = bits_q;
    assign state_o = state_q;

endmodule

// File: rtl/pfc_pinmux.sv
module pfc_pinmux
    import pfc_pkg::*;
#(
    parameter int NPINS = 3
) (
    input  logic             special_i,
    input  mode_kind_e       kind_i,
    input  ctl_bits_t        bits_i,
    input  logic             estr_i,
    input  logic [1:0]       pipe_stat_i,
    input  logic             clk_test_i,
    input  logic             eclk_i,
    input  logic [NPINS-1:0] gpio_out_i,
    input  logic [NPINS-1:0] gpio_oe_i,
    output pin_src_e         sel_o [NPINS],
    output logic [NPINS-1:0] oe_o,
    output logic [NPINS-1:0] do_o
);

    localparam int P6 = NPINS - 1;
    localparam int P5 = NPINS - 2;
    localparam int P4 = NPINS - 3;

    logic is_single, is_exp, is_periph;
    logic pipe_on, ctest_on, eclk_on;

    always_comb begin
        is_single = (kind_i == MK_SINGLE);
        is_periph = (kind_i == MK_PERIPH);
        is_exp    = (kind_i == MK_EXP) || (kind_i == MK_EXPW);
        pipe_on   = bits_i.ps && is_exp;
        ctest_on  = bits_i.ct && !pipe_on && !is_single && !(is_exp && !special_i);
        eclk_on   = !bits_i.ne && (!is_single || !estr_i);
    end

    // GPIO default for every pin, overridden below by alternate functions
    pin_src_e         gsel [NPINS];
    logic [NPINS-1:0] goe, gdo;
    for (genvar g = 0; g < NPINS; g++) begin : g_gpio
        assign gsel[g] = SRC_GPIO;
        assign goe[g]  = gpio_oe_i[g];
        assign gdo[g]  = gpio_out_i[g];
    end

    always_comb begin
        for (int i = 0; i < NPINS; i++) sel_o[i] = gsel[i];
        oe_o = goe;
        do_o = gdo;

        // Pin 6: pipe status over clock test over GPIO
        if (pipe_on) begin
            sel_o[P6] = SRC_PIPE;
            oe_o[P6]  = 1'b1;
            do_o[P6]  = pipe_stat_i[1];
        end else if (ctest_on) begin
            sel_o[P6] = SRC_CLKTEST;
            oe_o[P6]  = 1'b1;
            do_o[P6]  = clk_test_i;
        end

        // Pin 5: pipe status over GPIO
        if (pipe_on) begin
            sel_o[P5] = SRC_PIPE;
            oe_o[P5]  = 1'b1;
            do_o[P5]  = pipe_stat_i[0];
        end

        // Pin 4: E clock, an input in peripheral mode
        if (eclk_on) begin
            sel_o[P4] = SRC_ECLK;
            oe_o[P4]  = !is_periph;
            do_o[P4]  = is_periph ? 1'b0 : eclk_i;
        end
    end

endmodule

// File: rtl/pin_func_ctl.sv
module pin_func_ctl
    import pfc_pkg::*;
#(
    parameter int REG_W  = 8,
    parameter int CT_POS = 6,
    parameter int PS_POS = 5,
    parameter int NE_POS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_special_i,
    input  logic [1:0]       mode_kind_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             estr_i,
    input  logic [1:0]       pipe_stat_i,
    input  logic             clk_test_i,
    input  logic             eclk_i,
    input  logic [2:0]       gpio_out_i,
    input  logic [2:0]       gpio_oe_i,
    output logic [5:0]       pin_sel_o,
    output logic [2:0]       pin_oe_o,
    output logic [2:0]       pin_do_o
);

    localparam int NPINS = 3;
    localparam int SEL_W = $bits(pin_src_e);

    logic       spec_q;
    mode_kind_e kind_q;
    ctl_bits_t  bits;
    acc_state_e acc_state;
    logic       first_done;
    pin_src_e   sel [NPINS];

    pfc_mode_latch u_mode (
        .clk            (clk),
        .rst            (rst),
        .mode_special_i (mode_special_i),
        .mode_kind_i    (mode_kind_i),
        .special_q      (spec_q),
        .kind_q         (kind_q)
    );

    pfc_access #(
        .REG_W (REG_W), .CT_POS (CT_POS), .PS_POS (PS_POS), .NE_POS (NE_POS)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .special_i (spec_q),
        .kind_i    (kind_q),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .bits_o    (bits),
        .state_o   (acc_state)
    );

    pfc_pinmux #(.NPINS (NPINS)) u_mux (
        .special_i   (spec_q),
        .kind_i      (kind_q),
        .bits_i      (bits),
        .estr_i      (estr_i),
        .pipe_stat_i (pipe_stat_i),
        .clk_test_i  (clk_test_i),
        .eclk_i      (eclk_i),
        .gpio_out_i  (gpio_out_i),
        .gpio_oe_i   (gpio_oe_i),
        .sel_o       (sel),
        .oe_o        (pin_oe_o),
        .do_o        (pin_do_o)
    );

    assign first_done = (acc_state == ST_WRITTEN);

    always_comb begin
        rd_data_o         = '0;
        rd_data_o[CT_POS] = bits.ct;
        rd_data_o[PS_POS] = bits.ps;
        rd_data_o[NE_POS] = bits.ne;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_sel
        assign pin_sel_o[p*SEL_W +: SEL_W] = sel[p];
    end

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker
    import pfc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       spec_q,
    input mode_kind_e kind_q,
    input logic       first_done,
    input logic       wr_en_i,
    input logic [7:0] rd_data_o,
    input logic [5:0] pin_sel_o,
    input logic [2:0] pin_oe_o
);

    logic is_exp;
    assign is_exp = (kind_q == MK_EXP) || (kind_q == MK_EXPW);

    assert_ct_normal_never_R2: assert property (@(posedge clk) disable iff (rst)
        !spec_q |-> !rd_data_o[6]);

    assert_ct_first_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !first_done) |=> $stable(rd_data_o[6]));

    assert_ps_once_R3: assert property (@(posedge clk) disable iff (rst)
        (!spec_q && first_done) |=> $stable(rd_data_o[5]));

    assert_ne_never_R4: assert property (@(posedge clk) disable iff (rst)
        (kind_q != MK_SINGLE) |-> !rd_data_o[4]);

    assert_pipe_priority_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[5] && is_exp) |-> (pin_sel_o[5:4] == SRC_PIPE && pin_sel_o[3:2] == SRC_PIPE
                                      && pin_oe_o[2] && pin_oe_o[1]));

    assert_pipe_inert_R7: assert property (@(posedge clk) disable iff (rst)
        !is_exp |-> (pin_sel_o[5:4] != SRC_PIPE && pin_sel_o[3:2] != SRC_PIPE));

    assert_eclk_dir_R10: assert property (@(posedge clk) disable iff (rst)
        (pin_sel_o[1:0] == SRC_ECLK) |-> (pin_oe_o[0] == (kind_q != MK_PERIPH)));

    assert_mode_held_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(spec_q) && $stable(kind_q)));

endmodule

bind pin_func_ctl pfc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .spec_q     (spec_q),
    .kind_q     (kind_q),
    .first_done (first_done),
    .wr_en_i    (wr_en_i),
    .rd_data_o  (rd_data_o),
    .pin_sel_o  (pin_sel_o),
    .pin_oe_o   (pin_oe_o)
);

// File: tb/sim_pin_func_ctl.sv
`timescale 1ns/1ps
module sim_pin_func_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_special_i = 1'b0;
    logic [1:0] mode_kind_i = 2'b00;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       estr_i = 1'b0;
    logic [1:0] pipe_stat_i = 2'b10;
    logic       clk_test_i = 1'b1;
    logic       eclk_i = 1'b1;
    logic [2:0] gpio_out_i = 3'b010;
    logic [2:0] gpio_oe_i = 3'b101;
    logic [5:0] pin_sel_o;
    logic [2:0] pin_oe_o;
    logic [2:0] pin_do_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    bit m_sp;
    bit [1:0] m_kd;
    bit m_ct, m_ps, m_ne;
    int m_nwr;

    always #2 clk = ~clk;   // 250 MHz

    pin_func_ctl u0 (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (sp=%0d kind=%0d)", req, act, exp, m_sp, m_kd);
        end
    endtask

    task automatic do_reset(input bit sp, input bit [1:0] kd);
        @(negedge clk);
        rst = 1'b1; wr_en_i = 1'b0;
        mode_special_i = sp; mode_kind_i = kd;
        m_sp = sp; m_kd = kd; m_ct = 0; m_ps = 0; m_ne = 0; m_nwr = 0;
        @(negedge clk);
        chk("R1 read during reset", {8'h0, rd_data_o}, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        // R12: live mode inputs now disagree with the captured mode
        mode_special_i = ~sp; mode_kind_i = ~kd;
        chk("R1 read after reset", {8'h0, rd_data_o}, 16'h0000);
    endtask

    // Expected pin results, each pin as {sel[1:0], oe, do}
    task automatic check_pins();
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 2; p++) begin
                bit expd, single, periph;
                logic [3:0] x6, x5, x4;
                string r6, r5, r4;
                estr_i = e[0];
                pipe_stat_i = 2'b10 ^ {p[0], p[0]};
                clk_test_i  = 1'b1 ^ p[0];
                eclk_i      = 1'b1 ^ p[0];
                gpio_out_i  = 3'b010 ^ {3{p[0]}};
                gpio_oe_i   = 3'b101 ^ {3{p[0]}};
                #1;
                expd   = (m_kd == 2'b01) || (m_kd == 2'b11);
                single = (m_kd == 2'b00);
                periph = (m_kd == 2'b10);
                if (m_ps && expd) begin
                    x6 = {2'd1, 1'b1, pipe_stat_i[1]}; r6 = "R6 pin6 pipe";
                end else if (m_ct && !single && !(expd && !m_sp)) begin
                    x6 = {2'd2, 1'b1, clk_test_i}; r6 = "R8 pin6 clock test";
                end else begin
                    x6 = {2'd0, gpio_oe_i[2], gpio_out_i[2]}; r6 = "R7/R11 pin6 gpio";
                end
                if (m_ps && expd) begin
                    x5 = {2'd1, 1'b1, pipe_stat_i[0]}; r5 = "R6 pin5 pipe";
                end else begin
                    x5 = {2'd0, gpio_oe_i[1], gpio_out_i[1]}; r5 = "R7/R11 pin5 gpio";
                end
                if (!m_ne && (!single || !estr_i)) begin
                    x4 = {2'd3, !periph, periph ? 1'b0 : eclk_i}; r4 = "R9/R10 pin4 eclk";
                end else begin
                    x4 = {2'd0, gpio_oe_i[0], gpio_out_i[0]}; r4 = "R9/R11 pin4 gpio";
                end
                chk(r6, {12'h0, pin_sel_o[5:4], pin_oe_o[2], pin_do_o[2]}, {12'h0, x6});
                chk(r5, {12'h0, pin_sel_o[3:2], pin_oe_o[1], pin_do_o[1]}, {12'h0, x5});
                chk(r4, {12'h0, pin_sel_o[1:0], pin_oe_o[0], pin_do_o[0]}, {12'h0, x4});
            end
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        bit first;
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
        first = (m_nwr == 0);
        // R2 clock-test: special and not first
        if (m_sp && !first) m_ct = d[6];
        // R3 pipe: normal first only, special all but first
        if (m_sp ? !first : first) m_ps = d[5];
        // R4 no-E: single-chip only; normal first, special any
        if (m_kd == 2'b00 && (m_sp || first)) m_ne = d[4];
        m_nwr++;
        // R5 read-back layout
        chk("R2/R3/R4/R5 readback", {8'h0, rd_data_o},
            {8'h0, 1'b0, m_ct, m_ps, m_ne, 4'h0});
        check_pins();
    endtask

    initial begin
        logic [7:0] seq_a [4] = '{8'h70, 8'h50, 8'h20, 8'h70};
        logic [7:0] seq_b [4] = '{8'h00, 8'h70, 8'h10, 8'h00};
        for (int m = 0; m < 8; m++) begin
            do_reset(m[2], m[1:0]);
            check_pins();
            for (int k = 0; k < 4; k++) do_write(seq_a[k]);
            do_reset(m[2], m[1:0]);
            for (int k = 0; k < 4; k++) do_write(seq_b[k]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule